// File: doc/BRIEF.md
# TDM Frame Strobe Timer

This block turns a TDM backplane timing pair into the timing that a strobed-serial CODEC needs. The pair is a master clock at twice the bit rate and an active-low frame pulse. The block divides the master clock by two to make a bit clock. It decodes a position counter inside the 125 µs frame into two enable strobes, one per 8-bit timeslot. The strobes cover two adjacent channels. A static select input picks which pair of channels they cover: the first two channels of the frame, or the two channels that follow them.

The block also watches the frame-pulse line. A one-cycle low pulse restarts the frame position at zero. A line that stays high lets the position counter run free and wrap once per frame, so the bit clock and strobes keep going. A line that stays low for more than a short run of samples means no timing is present. In that case the bit clock is parked at a driven low level and both strobes are held low until the line returns high.

Top module: `tdm_strobe_timer`

## Requirements
- R1: While `rst_ni` is low, `bclk_o`, `strb_a_o` and `strb_b_o` are all low.
- R2: Outside the held-low condition, `bclk_o` has a period of two master-clock cycles and is high at even frame positions, including position 0.
- R3: A low sample of `fp_ni` restarts the frame. The outputs registered on the second master-clock edge after the edge that samples `fp_ni` low present frame position 0.
- R4: With `pair_sel_i` at 0, `strb_a_o` is high for frame positions 0 to 15 (channel 0), `strb_b_o` is high for positions 16 to 31 (channel 1), and both are low elsewhere.
- R5: With `pair_sel_i` at 1, `strb_a_o` is high for positions 32 to 47 (channel 2), `strb_b_o` is high for positions 48 to 63 (channel 3), and both are low elsewhere.
- R6: With `fp_ni` held high, the frame position runs free and wraps from 511 to 0, so the output pattern repeats every 512 master-clock cycles.
- R7: After more than 4 consecutive low samples of `fp_ni`, the block enters the held-low condition: `bclk_o` is driven low and both strobes stay low for as long as `fp_ni` stays low. A run of exactly 4 low samples does not enter it.
- R8: The first high sample of `fp_ni` ends the held-low condition. Timing then resumes with position 0 taken at the last low sample. That position-0 output stays low, and position 1 is the first position shown.
- R9: A frame pulse arriving partway through a frame realigns the position to 0 at once, with no wait for the running frame to end.
- R10: The two strobes are never high together. Each one stays high for exactly 16 consecutive master-clock cycles once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (4.096 MHz in the target system) |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fp_ni | input | 1 | Active-low frame pulse, one master-clock cycle wide |
| pair_sel_i | input | 1 | Static channel-pair select: 0 gives channels 0/1, 1 gives channels 2/3 |
| bclk_o | output | 1 | Bit clock at half the master-clock rate |
| strb_a_o | output | 1 | Enable strobe for the first channel of the selected pair |
| strb_b_o | output | 1 | Enable strobe for the second channel of the selected pair |

## Verification
The bench builds the block with its default parameters: 8-bit slots, 32 slots per frame, two master-clock cycles per bit and a held-low limit of 4 samples. With these values a whole 512-cycle frame and its wrap fit in a few thousand cycles, so every position of both channel pairs is compared, and so is the free-running repeat. The small limit makes the boundary easy to reach: the bench drives a run of exactly 4 low samples, a longer held-low stretch, and the release that follows it. It also drives a pulse in the middle of a frame.

// File: rtl/tdm_strobe_pkg.sv
package tdm_strobe_pkg;

  // Default frame geometry
  localparam int unsigned SLOT_BITS_D    = 8;   // bits per timeslot
  localparam int unsigned NUM_SLOTS_D    = 32;  // timeslots per frame
  localparam int unsigned MCLK_PER_BIT_D = 2;   // master cycles per bit (power of two)
  localparam int unsigned LOW_LIMIT_D    = 4;   // low samples tolerated before held-low
  localparam int unsigned PAIR_STRIDE_D  = 2;   // slot offset of the alternate pair
  localparam int unsigned NUM_STRB       = 2;   // strobes per pair

  // Registered output bundle
  typedef struct packed {
    logic                bclk;
    logic [NUM_STRB-1:0] strb;
  } tdm_out_t;

endpackage

// File: rtl/tdm_rst_sync.sv
module tdm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  // Assert asynchronously, release after STAGES clock edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/tdm_fp_watch.sv
module tdm_fp_watch #(
  parameter int unsigned LOW_LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fp_ni,
  output logic fp_s_o,     // registered frame-pulse sample
  output logic held_o      // line held low
);

  localparam int unsigned RUN_MAX = LOW_LIMIT + 1;
  localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_MAX);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(LOW_LIMIT);

  logic             fp_q;
  logic [RUN_W-1:0] run_q, run_d;
  logic             held_q, held_d;
  logic             run_en;

  // Run counter: counts consecutive low samples, saturating
  always_comb begin
    run_en = fp_q || (run_q != RUN_TOP);
    if (fp_q) begin
      run_d = '0;
    end else begin
      run_d = run_q + RUN_W'(1);
    end
  end

  // Held-low: current sample low and at least LOW_LIMIT lows before it
  always_comb begin
    held_d = !fp_q && (run_q >= RUN_LIM);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_q   <= 1'b1;
      run_q  <= '0;
      held_q <= 1'b0;
    end else begin
      fp_q   <= fp_ni;
      held_q <= held_d;
      if (run_en) begin
        run_q <= run_d;
      end
    end
  end

  assign fp_s_o = fp_q;
  assign held_o = held_q;

endmodule

// File: rtl/tdm_frame_cnt.sv
module tdm_frame_cnt #(
  parameter int unsigned FRAME_LEN = 512,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_s_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!fp_s_i) begin
      cnt_d = '0;                    // resynchronise on pulse
    end else if (cnt_q == LAST) begin
      cnt_d = '0;                    // free-running wrap
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tdm_strobe_gen.sv
module tdm_strobe_gen
  import tdm_strobe_pkg::*;
#(
  parameter int unsigned CNT_W     = 9,
  parameter int unsigned SLOT_SH   = 4,   // log2 master cycles per slot
  parameter int unsigned PHASE_SH  = 1,   // log2 master cycles per bit
  parameter int unsigned ALT_BASE  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             held_i,
  input  logic             sel_i,
  output tdm_out_t         out_o
);

  localparam int unsigned SLOT_W = CNT_W - SLOT_SH;
  localparam logic [SLOT_W-1:0] ALT = SLOT_W'(ALT_BASE);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] base;
  tdm_out_t          out_d, out_q;

  assign slot = cnt_i[CNT_W-1:SLOT_SH];
  assign base = sel_i ? ALT : '0;

  // Bit clock: high in the first half of each bit period
  assign out_d.bclk = !held_i && !cnt_i[PHASE_SH-1];

  // One strobe per slot of the selected pair
  for (genvar k = 0; k < NUM_STRB; k++) begin : g_strb
    assign out_d.strb[k] = !held_i && (slot == (base + SLOT_W'(k)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
    end else begin
      out_q <= out_d;
    end
  end

  assign out_o = out_q;

endmodule

// File: rtl/tdm_strobe_timer.sv
module tdm_strobe_timer
  import tdm_strobe_pkg::*;
#(
  parameter int unsigned SLOT_BITS    = SLOT_BITS_D,
  parameter int unsigned NUM_SLOTS    = NUM_SLOTS_D,
  parameter int unsigned MCLK_PER_BIT = MCLK_PER_BIT_D,
  parameter int unsigned LOW_LIMIT    = LOW_LIMIT_D,
  parameter int unsigned PAIR_STRIDE  = PAIR_STRIDE_D
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fp_ni,
  input  logic pair_sel_i,
  output logic bclk_o,
  output logic strb_a_o,
  output logic strb_b_o
);

  localparam int unsigned SLOT_CYC  = SLOT_BITS * MCLK_PER_BIT;
  localparam int unsigned FRAME_LEN = SLOT_CYC * NUM_SLOTS;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN);
  localparam int unsigned SLOT_SH   = $clog2(SLOT_CYC);
  localparam int unsigned PHASE_SH  = $clog2(MCLK_PER_BIT);

  logic             rst_sync_n;
  logic             fp_s;
  logic             held;
  logic [CNT_W-1:0] cnt;
  tdm_out_t         outs;

  tdm_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  tdm_fp_watch #(.LOW_LIMIT(LOW_LIMIT)) i_fp_watch (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .fp_ni  (fp_ni),
    .fp_s_o (fp_s),
    .held_o (held)
  );

  tdm_frame_cnt #(.FRAME_LEN(FRAME_LEN)) i_frame_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .fp_s_i (fp_s),
    .cnt_o  (cnt)
  );

  tdm_strobe_gen #(
    .CNT_W    (CNT_W),
    .SLOT_SH  (SLOT_SH),
    .PHASE_SH (PHASE_SH),
    .ALT_BASE (PAIR_STRIDE)
  ) i_strobe_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .cnt_i  (cnt),
    .held_i (held),
    .sel_i  (pair_sel_i),
    .out_o  (outs)
  );

  assign bclk_o   = outs.bclk;
  assign strb_a_o = outs.strb[0];
  assign strb_b_o = outs.strb[1];

endmodule

// File: rtl/tdm_strobe_timer_chk.sv
module tdm_strobe_timer_chk #(
  parameter int unsigned CNT_W     = 9,
  parameter int unsigned FRAME_LEN = 512
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             fp_s,
  input logic             held,
  input logic [CNT_W-1:0] cnt,
  input logic             bclk,
  input logic             en_a,
  input logic             en_b
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  // R10: strobes mutually exclusive
  a_r10_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(en_a && en_b));

  // R7: held-low state silences every output on the next edge
  a_r7_held_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
    held |=> (!bclk && !en_a && !en_b));

  // R3: a low frame-pulse sample brings the position to zero
  a_r3_resync_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    !fp_s |=> (cnt == '0));

  // R6: last position of the frame is followed by zero
  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cnt == LAST) |=> (cnt == '0));

  // R8: a high sample during held-low ends it
  a_r8_leave_held: assert property (@(posedge clk_i) disable iff (!rst_n)
    (held && fp_s) |=> !held);

endmodule

bind tdm_strobe_timer tdm_strobe_timer_chk #(
  .CNT_W     (CNT_W),
  .FRAME_LEN (FRAME_LEN)
) i_chk (
  .clk_i (clk_i),
  .rst_n (rst_sync_n),
  .fp_s  (fp_s),
  .held  (held),
  .cnt   (cnt),
  .bclk  (bclk_o),
  .en_a  (strb_a_o),
  .en_b  (strb_b_o)
);

// File: tb/test_tdm_strobe_timer.sv
module test_tdm_strobe_timer;

  localparam int FRAME    = 512;
  localparam int SLOT_CYC = 16;
  localparam int LIMIT    = 4;
  localparam int LAT      = 3;   // drive negedge to observation negedge of position 0

  typedef struct packed {
    logic [15:0] tag;
    logic        bclk;
    logic        a;
    logic        b;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic fp_ni;
  logic pair_sel_i;
  logic bclk_o, strb_a_o, strb_b_o;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  logic sel_cur = 1'b0;
  logic [15:0] tag = "R3";
  logic d_r  [16];
  logic e_r  [16];
  int   ll_r [16];
  exp_t q [$];

  always #10 clk_i = ~clk_i;   // 50 MHz

  tdm_strobe_timer i_tdm_strobe_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fp_ni      (fp_ni),
    .pair_sel_i (pair_sel_i),
    .bclk_o     (bclk_o),
    .strb_a_o   (strb_a_o),
    .strb_b_o   (strb_b_o)
  );

  // Driver: one negedge per call, pushes the expectation for this observation
  task automatic step(input logic fpn);
    exp_t e;
    logic held;
    int   pos, slot, base;
    @(negedge clk_i);
    if (n >= 8 && ll_r[(n-LAT)%16] >= 0) begin
      held = 1'b1;
      for (int j = LAT; j <= LAT + LIMIT; j++) if (d_r[(n-j)%16]) held = 1'b0;
      if (held) begin
        e = '{tag: "R7", bclk: 1'b0, a: 1'b0, b: 1'b0};
      end else begin
        pos  = ((n - LAT) - ll_r[(n-LAT)%16]) % FRAME;
        slot = pos / SLOT_CYC;
        base = e_r[(n-1)%16] ? 2 : 0;
        e.tag  = tag;
        e.bclk = (pos % 2) == 0;
        e.a    = (slot == base);
        e.b    = (slot == base + 1);
      end
      q.push_back(e);
    end
    fp_ni      = fpn;
    pair_sel_i = sel_cur;
    d_r[n%16]  = fpn;
    e_r[n%16]  = sel_cur;
    ll_r[n%16] = fpn ? ((n > 0) ? ll_r[(n-1)%16] : -1) : n;
    n++;
  endtask

  task automatic run_high(input int cyc);
    for (int i = 0; i < cyc; i++) step(1'b1);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Monitor: scoreboard compare, away from the edge
  always @(negedge clk_i) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (bclk_o !== e.bclk) begin
        fails++;
        $display("FAIL %s/R2 bclk at obs %0d: got %b exp %b", e.tag, n, bclk_o, e.bclk);
      end else if (strb_a_o !== e.a || strb_b_o !== e.b) begin
        fails++;
        $display("FAIL %s/R10 strobes at obs %0d: got %b%b exp %b%b",
                 e.tag, n, strb_a_o, strb_b_o, e.a, e.b);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      d_r[i] = 1'b1; e_r[i] = 1'b0; ll_r[i] = -1;
    end
    rst_ni = 1'b0; fp_ni = 1'b1; pair_sel_i = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1: outputs low in reset
    for (int i = 0; i < 2; i++) begin
      @(negedge clk_i); #2;
      checks++;
      if ({bclk_o, strb_a_o, strb_b_o} !== 3'b000) begin
        fails++;
        $display("FAIL R1 reset outputs: got %b exp 000", {bclk_o, strb_a_o, strb_b_o});
      end
    end
    rst_ni = 1'b1;
    run_high(10);

    // R3/R4: pulse with pair 0/1, first frame
    tag = "R3"; step(1'b0);
    tag = "R4"; run_high(520);
    // R6: no more pulses, free-running wrap
    tag = "R6"; run_high(600);
    // R9: pulse in mid-frame
    tag = "R9"; step(1'b0); run_high(200);
    // R5: pair 2/3
    sel_cur = 1'b1;
    tag = "R5"; step(1'b0); run_high(540);
    // R7 boundary: exactly LIMIT lows, no held-low
    tag = "R7";
    for (int i = 0; i < LIMIT; i++) step(1'b0);
    run_high(80);
    // R7: long held-low stretch
    for (int i = 0; i < 40; i++) step(1'b0);
    // R8: release resumes from last low sample
    tag = "R8"; run_high(120);
    sel_cur = 1'b0;
    tag = "R4"; run_high(520);

    while (q.size() > 0) @(negedge clk_i);
    @(negedge clk_i); #4;
    summary();
    $finish;
  end

endmodule